// File: doc/BRIEF.md
# Register-Immediate Arithmetic Execution Core

This block is a small sequential processor core. It holds a local instruction store that is filled through a load port while the core is stopped. A start pulse makes it run the stored program from address 0. Each instruction is a 24-bit word, and each one is fetched, decoded and then executed over a fixed number of cycles. The instruction set has move, add, subtract, multiply and divide. Each of these has one form that takes its second operand from a register and one form that takes it from an immediate value. A halt instruction ends the program.

Machine state is held in eight 16-bit general registers and two further 16-bit registers. One of the two receives the upper half of a product and the other receives the remainder of a division. The core counts the cycles it spends running and the instructions it retires, so a testbench can divide one count by the other to get the average CPI of a program. Two flags report problems: one for an illegal instruction and one for a division by zero. An observation port lets the testbench read any register.

Top module: `arith_core`

## Requirements
- R1: An instruction word carries its opcode in bits 23:19, the destination register index in bits 18:16 and a 16-bit operand field in bits 15:0. Opcode bit 0 set selects the immediate form. Opcode bit 0 clear selects the register form, which takes the source index from bits 2:0. The defined opcodes are move 00000/00001, add 00010/00011, subtract 00100/00101, multiply 00110/00111, divide 01000/01001 and halt 11111.
- R2: Move copies the source into the destination. Add and subtract compute destination op source as unsigned values and wrap modulo 2^16.
- R3: Multiply forms the full 32-bit unsigned product of the destination and the source. The low 16 bits go to the destination and the high 16 bits go to the product-high register.
- R4: Divide writes the unsigned quotient of the destination divided by the source to the destination, and the remainder to the remainder register.
- R5: A divide by zero leaves the destination unchanged and copies the dividend into the remainder register. It also sets err_div0, which stays set until the next accepted start, and execution continues.
- R6: The halt opcode 11111 stops the core. done is high in every cycle while the core is stopped after a run.
- R7: The core stops without retiring the instruction and sets err_illegal when it meets either of two cases: an undefined opcode, or a register form with any of operand bits 15:3 set. No register changes.
- R8: Each instruction costs one fetch cycle plus 1 execute cycle for move, add and subtract, 4 for multiply and 17 for divide. Halt costs one cycle and counts as retired. cycles and instret are 32 bits wide and do not change while the core is stopped.
- R9: Reset clears all registers, both flags and both counters, and leaves done low. A start pulse while the core is idle or stopped clears the counters and flags, keeps the register values and begins fetching at address 0.
- R10: Writes on the load port take effect only while the core is idle or stopped. Writes made while it runs are ignored.
- R11: obs_data shows the register picked by obs_sel in the same cycle: 0–7 pick the general registers, 8 the product-high register, 9 the remainder register, and any other value reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Instruction store write strobe |
| load_addr | input | clog2(IMEM_DEPTH) | Instruction store write address |
| load_data | input | 24 | Instruction word to write |
| start | input | 1 | Begin running at address 0 |
| obs_sel | input | 4 | Register picked for observation |
| obs_data | output | 16 | Value of the observed register |
| done | output | 1 | Core has stopped after a run |
| err_illegal | output | 1 | Run stopped on an illegal instruction |
| err_div0 | output | 1 | A divide by zero happened in this run |
| cycles | output | 32 | Cycles spent running |
| instret | output | 32 | Instructions retired |

## Verification
A wrong decode or a wrong result path shows up as a wrong register value at obs_data once done rises. A wrong iteration count in the divider shows up as a wrong quotient or remainder. A wrong execute length does not corrupt any register, so it shows only as a cycles value that differs from the per-opcode sum. That makes the cycles count at done the main check of the cycle costs. An unsafe load port or a wrong halt condition shows as a later instruction that produces the wrong register value, or as done rising with the wrong instret.

// File: rtl/arith_core_pkg.sv
// Shared constants, types and the instruction decoder for the arithmetic core.
// Assumes the 24-bit word layout: opcode[23:19], rd[18:16], operand[15:0].
package arith_core_pkg;
    localparam int DATA_W   = 16;
    localparam int OPC_W    = 5;
    localparam int RIDX_W   = 3;
    localparam int INSTR_W  = OPC_W + RIDX_W + DATA_W;
    localparam int OPC_LSB  = RIDX_W + DATA_W;
    localparam int RD_LSB   = DATA_W;
    localparam int NUM_GPR  = 1 << RIDX_W;
    localparam logic [OPC_W-1:0] OPC_HALT = 5'b11111;
    localparam logic [OPC_W-1:0] OPC_LAST_ARITH = 5'b01001;

    // Operation kind; value equals opcode bits 3:1 of the arithmetic codes.
    typedef enum logic [2:0] {
        K_MOV = 3'd0,
        K_ADD = 3'd1,
        K_SUB = 3'd2,
        K_MUL = 3'd3,
        K_DIV = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic  legal;
        logic  halt;
        logic  use_imm;
        kind_e kind;
    } dec_t;

    // Classify one instruction word.
    function automatic dec_t decode_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        logic [OPC_W-1:0] opc;
        opc       = w[OPC_LSB +: OPC_W];
        d.legal   = 1'b1;
        d.halt    = 1'b0;
        d.use_imm = opc[0];
        d.kind    = K_MOV;
        if (opc == OPC_HALT) begin
            d.halt = 1'b1;
        end else if (opc <= OPC_LAST_ARITH) begin
            d.kind = kind_e'(opc[3:1]);
            if (!opc[0] && (|w[DATA_W-1:RIDX_W]))
                d.legal = 1'b0;
        end else begin
            d.legal = 1'b0;
        end
        return d;
    endfunction
endpackage

// File: rtl/ac_imem.sv
// Instruction store: one synchronous write port, one combinational read port.
// Assumes the writer guarantees no write to an address being fetched.
module ac_imem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ac_regfile.sv
// General registers plus product-high and remainder registers.
// Two operand read ports, one observation read port; all reads combinational.
module ac_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gpr_we,
    input  logic [IW-1:0] gpr_waddr,
    input  logic [DW-1:0] gpr_wdata,
    input  logic          hi_we,
    input  logic [DW-1:0] hi_wdata,
    input  logic          rem_we,
    input  logic [DW-1:0] rem_wdata,
    input  logic [IW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic [3:0]    obs_sel,
    output logic [DW-1:0] obs_data
);
    logic [DW-1:0] gpr [NREG];
    logic [DW-1:0] hi_q;
    logic [DW-1:0] rem_q;

    // One register per generated slot, written on index match.
    for (genvar g = 0; g < NREG; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr[g] <= '0;
            else if (gpr_we && gpr_waddr == IW'(g))
                gpr[g] <= gpr_wdata;
        end
    end

    // Special registers for product high half and remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            rem_q <= '0;
        end else begin
            if (hi_we)
                hi_q <= hi_wdata;
            if (rem_we)
                rem_q <= rem_wdata;
        end
    end

    assign ra_data = gpr[ra_addr];
    assign rb_data = gpr[rb_addr];

    // Observation mux: general registers, then high, then remainder.
    always_comb begin
        if (obs_sel < 4'(NREG))
            obs_data = gpr[obs_sel[IW-1:0]];
        else if (obs_sel == 4'(NREG))
            obs_data = hi_q;
        else if (obs_sel == 4'(NREG + 1))
            obs_data = rem_q;
        else
            obs_data = '0;
    end
endmodule

// File: rtl/ac_divider.sv
// Iterative restoring unsigned divider, one quotient bit per cycle.
// go loads the operands; W-1 register steps follow; the W-th step is offered
// combinationally on quo_nxt/rem_nxt so the caller can write it back directly.
// Operands must stay stable for the whole operation.
module ac_divider #(
    parameter int W   = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo_nxt,
    output logic [W-1:0] rem_nxt
);
    logic [W-1:0]  quo_q;
    logic [W-1:0]  rem_q;
    logic [CW-1:0] cnt_q;
    logic [W+1:0]  trial;

    // One restoring step: shift in the next dividend bit and try a subtract.
    always_comb begin
        trial = {1'b0, rem_q, quo_q[W-1]} - {2'b00, divisor};
        if (!trial[W+1]) begin
            rem_nxt = trial[W-1:0];
            quo_nxt = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_nxt = {rem_q[W-2:0], quo_q[W-1]};
            quo_nxt = {quo_q[W-2:0], 1'b0};
        end
    end

    // Load on go, then advance one step per cycle while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (go) begin
            quo_q <= dividend;
            rem_q <= '0;
            cnt_q <= CW'(W);
        end else if (cnt_q != '0) begin
            quo_q <= quo_nxt;
            rem_q <= rem_nxt;
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/arith_core.sv
// Multi-cycle register/immediate arithmetic core. Fetches one 24-bit word,
// decodes it, spends a fixed execute time per kind, then writes back.
// Assumes the program is loaded before start; the store is locked while running.
module arith_core
    import arith_core_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int CNT_W      = 32,
    parameter int MUL_EXEC   = 4,
    localparam int AW        = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [AW-1:0]      load_addr,
    input  logic [INSTR_W-1:0] load_data,
    input  logic               start,
    input  logic [3:0]         obs_sel,
    output logic [DATA_W-1:0]  obs_data,
    output logic               done,
    output logic               err_illegal,
    output logic               err_div0,
    output logic [CNT_W-1:0]   cycles,
    output logic [CNT_W-1:0]   instret
);
    localparam int DIV_EXEC = DATA_W + 1;
    localparam int EW       = $clog2(DIV_EXEC);

    state_e               state_q;
    logic [AW-1:0]        pc_q;
    logic [INSTR_W-1:0]   ir_q;
    logic [EW-1:0]        ecnt_q;
    logic [EW-1:0]        ecnt_init;
    logic [INSTR_W-1:0]   fetch_word;
    dec_t                 dec_f;
    dec_t                 dec_x;
    logic                 stopped;
    logic                 wb;
    logic [DATA_W-1:0]    opa;
    logic [DATA_W-1:0]    rb_data;
    logic [DATA_W-1:0]    opb;
    logic [2*DATA_W-1:0]  product;
    logic [DATA_W-1:0]    quo_nxt;
    logic [DATA_W-1:0]    rem_nxt;
    logic                 div_zero;
    logic                 div_go;
    logic [DATA_W-1:0]    result;
    logic                 gpr_we;

    assign stopped = (state_q == ST_IDLE) || (state_q == ST_HALT);
    assign done    = (state_q == ST_HALT);

    ac_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (load_en && stopped),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc_q),
        .rdata (fetch_word)
    );

    assign dec_f = decode_word(fetch_word);
    assign dec_x = decode_word(ir_q);

    // Execute length minus one for the word being fetched.
    always_comb begin
        case (dec_f.kind)
            K_MUL:   ecnt_init = EW'(MUL_EXEC - 1);
            K_DIV:   ecnt_init = EW'(DIV_EXEC - 1);
            default: ecnt_init = '0;
        endcase
    end

    ac_regfile #(.DW(DATA_W), .NREG(NUM_GPR)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpr_we    (gpr_we),
        .gpr_waddr (ir_q[RD_LSB +: RIDX_W]),
        .gpr_wdata (result),
        .hi_we     (wb && dec_x.kind == K_MUL),
        .hi_wdata  (product[2*DATA_W-1:DATA_W]),
        .rem_we    (wb && dec_x.kind == K_DIV),
        .rem_wdata (div_zero ? opa : rem_nxt),
        .ra_addr   (ir_q[RD_LSB +: RIDX_W]),
        .ra_data   (opa),
        .rb_addr   (ir_q[RIDX_W-1:0]),
        .rb_data   (rb_data),
        .obs_sel   (obs_sel),
        .obs_data  (obs_data)
    );

    assign opb      = dec_x.use_imm ? ir_q[DATA_W-1:0] : rb_data;
    assign product  = opa * opb;
    assign div_zero = (opb == '0);
    assign div_go   = (state_q == ST_EXEC) && (dec_x.kind == K_DIV)
                      && (ecnt_q == EW'(DIV_EXEC - 1));
    assign wb       = (state_q == ST_EXEC) && (ecnt_q == '0);
    assign gpr_we   = wb && !(dec_x.kind == K_DIV && div_zero);

    ac_divider #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (opa),
        .divisor  (opb),
        .quo_nxt  (quo_nxt),
        .rem_nxt  (rem_nxt)
    );

    // Destination value per operation kind.
    always_comb begin
        case (dec_x.kind)
            K_ADD:   result = opa + opb;
            K_SUB:   result = opa - opb;
            K_MUL:   result = product[DATA_W-1:0];
            K_DIV:   result = quo_nxt;
            default: result = opb;
        endcase
    end

    // Sequencer: idle/halt -> fetch -> execute -> fetch ... -> halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pc_q        <= '0;
            ir_q        <= '0;
            ecnt_q      <= '0;
            cycles      <= '0;
            instret     <= '0;
            err_illegal <= 1'b0;
            err_div0    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_HALT: begin
                    if (start) begin
                        state_q     <= ST_FETCH;
                        pc_q        <= '0;
                        cycles      <= '0;
                        instret     <= '0;
                        err_illegal <= 1'b0;
                        err_div0    <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    cycles <= cycles + 1'b1;
                    if (!dec_f.legal) begin
                        err_illegal <= 1'b1;
                        state_q     <= ST_HALT;
                    end else if (dec_f.halt) begin
                        instret <= instret + 1'b1;
                        state_q <= ST_HALT;
                    end else begin
                        ir_q    <= fetch_word;
                        ecnt_q  <= ecnt_init;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    cycles <= cycles + 1'b1;
                    if (ecnt_q == '0) begin
                        instret <= instret + 1'b1;
                        pc_q    <= pc_q + 1'b1;
                        state_q <= ST_FETCH;
                        if (dec_x.kind == K_DIV && div_zero)
                            err_div0 <= 1'b1;
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/arith_core_chk.sv
// Port-level protocol checks for arith_core, bound to every instance.
module arith_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             err_illegal,
    input logic             err_div0,
    input logic [CNT_W-1:0] cycles,
    input logic [CNT_W-1:0] instret
);
    assert_cycles_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cycles == $past(cycles)) || (cycles == $past(cycles) + 1'b1));

    assert_instret_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (instret == $past(instret)) || (instret == $past(instret) + 1'b1));

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(cycles) && $stable(instret));

    assert_instret_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        instret <= cycles);

    assert_illegal_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> done);

    assert_div0_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_div0 && !start |=> err_div0);
endmodule

bind arith_core arith_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .err_illegal (err_illegal),
    .err_div0    (err_div0),
    .cycles      (cycles),
    .instret     (instret)
);

// File: tb/arith_core_bench.sv
// Directed bench for arith_core: one task per scenario, each checking itself.
module arith_core_bench;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [23:0] load_data = '0;
    logic        start = 1'b0;
    logic [3:0]  obs_sel = '0;
    logic [15:0] obs_data;
    logic        done;
    logic        err_illegal;
    logic        err_div0;
    logic [31:0] cycles;
    logic [31:0] instret;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    arith_core #(.IMEM_DEPTH(DEPTH)) u_arith_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .obs_sel(obs_sel),
        .obs_data(obs_data), .done(done), .err_illegal(err_illegal),
        .err_div0(err_div0), .cycles(cycles), .instret(instret)
    );

    // Opcodes written out from R1.
    localparam logic [4:0] MOVR = 5'b00000, MOVI = 5'b00001;
    localparam logic [4:0] ADDR = 5'b00010, ADDI = 5'b00011;
    localparam logic [4:0] SUBR = 5'b00100, SUBI = 5'b00101;
    localparam logic [4:0] MULR = 5'b00110, MULI = 5'b00111;
    localparam logic [4:0] DIVR = 5'b01000, DIVI = 5'b01001;
    localparam logic [4:0] HALT = 5'b11111;

    function automatic logic [23:0] enc(input logic [4:0] op, input logic [2:0] rd,
                                        input logic [15:0] f);
        return {op, rd, f};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [23:0] w);
        @(negedge clk);
        load_en   = 1'b1;
        load_addr = AW'(addr);
        load_data = w;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R6 done reached", {31'd0, done}, 32'd1);
    endtask

    task automatic run();
        kick();
        wait_done();
    endtask

    function automatic logic [15:0] peek_now(input int sel);
        return 16'(sel);
    endfunction

    task automatic peek(input int sel, output logic [15:0] v);
        obs_sel = 4'(sel);
        #1;
        v = obs_data;
    endtask

    task automatic check_reg(input string req, input int sel, input logic [15:0] exp);
        logic [15:0] v;
        peek(sel, v);
        check(req, {16'd0, v}, {16'd0, exp});
    endtask

    // R9 / R11: state after reset.
    task automatic t_reset();
        check("R9 done low after reset", {31'd0, done}, 32'd0);
        check("R9 cycles zero after reset", cycles, 32'd0);
        check("R9 instret zero after reset", instret, 32'd0);
        check("R9 flags clear after reset", {30'd0, err_illegal, err_div0}, 32'd0);
        for (int i = 0; i < 10; i++) check_reg("R9 register zero after reset", i, 16'd0);
    endtask

    // R1 / R2 / R8: move, add, subtract in both forms, including wrap.
    task automatic t_arith();
        put(0, enc(MOVI, 3'd1, 16'd1000));
        put(1, enc(MOVI, 3'd2, 16'd300));
        put(2, enc(ADDR, 3'd1, 16'd2));
        put(3, enc(SUBI, 3'd2, 16'd301));
        put(4, enc(ADDI, 3'd3, 16'hFFFF));
        put(5, enc(ADDI, 3'd3, 16'd2));
        put(6, enc(MOVR, 3'd4, 16'd1));
        put(7, enc(HALT, 3'd0, 16'd0));
        run();
        check_reg("R2 add register form", 1, 16'd1300);
        check_reg("R2 subtract wraps", 2, 16'hFFFF);
        check_reg("R2 add wraps", 3, 16'd1);
        check_reg("R1 move register form", 4, 16'd1300);
        check("R8 cycles single-cycle ops", cycles, 32'd15);
        check("R8 instret single-cycle ops", instret, 32'd8);
        repeat (10) @(negedge clk);
        check("R8 cycles frozen while stopped", cycles, 32'd15);
        check("R6 done held", {31'd0, done}, 32'd1);
    endtask

    // R3 / R8: multiply both forms.
    task automatic t_mul();
        logic [31:0] p1;
        p1 = 32'h1234 * 32'h5678;
        put(0, enc(MOVI, 3'd1, 16'h1234));
        put(1, enc(MOVI, 3'd2, 16'h5678));
        put(2, enc(MULR, 3'd1, 16'd2));
        put(3, enc(MOVI, 3'd3, 16'd300));
        put(4, enc(MULI, 3'd3, 16'd1000));
        put(5, enc(HALT, 3'd0, 16'd0));
        run();
        check_reg("R3 product low register form", 1, p1[15:0]);
        check_reg("R3 product low immediate form", 3, 16'h93E0);
        check_reg("R3 product high register", 8, 16'h0004);
        check("R8 cycles with multiply", cycles, 32'd17);
        check("R8 instret with multiply", instret, 32'd6);
    endtask

    // R4 / R8: divide both forms.
    task automatic t_div();
        put(0, enc(MOVI, 3'd1, 16'd1000));
        put(1, enc(DIVI, 3'd1, 16'd7));
        put(2, enc(MOVI, 3'd2, 16'd65535));
        put(3, enc(MOVI, 3'd3, 16'd256));
        put(4, enc(DIVR, 3'd2, 16'd3));
        put(5, enc(MOVI, 3'd4, 16'd5));
        put(6, enc(DIVI, 3'd4, 16'd9));
        put(7, enc(HALT, 3'd0, 16'd0));
        run();
        check_reg("R4 quotient immediate form", 1, 16'd142);
        check_reg("R4 quotient register form", 2, 16'd255);
        check_reg("R4 quotient below divisor", 4, 16'd0);
        check_reg("R4 remainder register", 9, 16'd5);
        check("R8 cycles with divide", cycles, 32'd63);
        check("R8 instret with divide", instret, 32'd8);
    endtask

    // R5 / R9: divide by zero, continuation, then restart clears flags.
    task automatic t_div0();
        put(0, enc(MOVI, 3'd5, 16'd1234));
        put(1, enc(DIVI, 3'd5, 16'd0));
        put(2, enc(MOVI, 3'd6, 16'd9));
        put(3, enc(HALT, 3'd0, 16'd0));
        run();
        check_reg("R5 destination kept", 5, 16'd1234);
        check_reg("R5 remainder takes dividend", 9, 16'd1234);
        check_reg("R5 execution continues", 6, 16'd9);
        check("R5 flag set", {31'd0, err_div0}, 32'd1);
        check("R5 no illegal flag", {31'd0, err_illegal}, 32'd0);
        put(0, enc(HALT, 3'd0, 16'd0));
        run();
        check("R9 restart clears flag", {31'd0, err_div0}, 32'd0);
        check("R8 halt costs one cycle", cycles, 32'd1);
        check("R8 halt retires", instret, 32'd1);
        check_reg("R9 registers kept over restart", 6, 16'd9);
    endtask

    // R7: undefined opcode and malformed register form.
    task automatic t_illegal();
        put(0, enc(MOVI, 3'd1, 16'd5));
        put(1, enc(5'b01010, 3'd1, 16'd0));
        put(2, enc(MOVI, 3'd1, 16'd6));
        put(3, enc(HALT, 3'd0, 16'd0));
        run();
        check_reg("R7 undefined opcode stops", 1, 16'd5);
        check("R7 illegal flag", {31'd0, err_illegal}, 32'd1);
        check("R7 not retired", instret, 32'd1);
        check("R7 cycles at stop", cycles, 32'd3);
        put(1, enc(ADDR, 3'd1, 16'h0008));
        run();
        check_reg("R7 malformed register form stops", 1, 16'd5);
        check("R7 illegal flag on malformed form", {31'd0, err_illegal}, 32'd1);
        check("R7 malformed not retired", instret, 32'd1);
    endtask

    // R10: a store write during a run is dropped.
    task automatic t_load_locked();
        put(0, enc(MOVI, 3'd1, 16'd100));
        put(1, enc(DIVI, 3'd1, 16'd3));
        put(2, enc(MOVI, 3'd2, 16'd7));
        put(3, enc(HALT, 3'd0, 16'd0));
        kick();
        repeat (6) @(negedge clk);
        load_en = 1'b1; load_addr = AW'(2); load_data = enc(MOVI, 3'd2, 16'd99);
        @(negedge clk);
        load_en = 1'b0;
        wait_done();
        check_reg("R10 write while running ignored", 2, 16'd7);
        check_reg("R4 quotient of 100/3", 1, 16'd33);
        check_reg("R4 remainder of 100/3", 9, 16'd1);
    endtask

    // R11: out-of-range selection reads zero.
    task automatic t_obs();
        check_reg("R11 unused selection reads zero", 12, 16'd0);
        check_reg("R11 general register selection", 2, 16'd7);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_mul();
        t_div();
        t_div0();
        t_illegal();
        t_load_locked();
        t_obs();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule